// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a memory-mapped system timer. It is clocked by the bus clock and advances on a one-cycle slow-clock enable (`slow_tick`) that marks each 32768 Hz period. It contains a prescaled real-time counter, an absolute alarm comparator, a periodic down-counter with reload, and a watchdog down-counter. The watchdog is modelled only as far as its overflow event. Four sticky event flags collect in a status word. A mask is built from separate set and clear registers, and the masked status drives one level interrupt.

Software works the block over a single-cycle bus. Writes land at the clock edge of the bus cycle. Read data is combinational during the cycle. A read of the status word clears the flags at the end of that cycle. The counter is read through a sampler that only passes a value on once two consecutive samples agree, so a read never returns a count that is in the middle of changing.

Top module: `slowclk_sys_timer`

## Requirements
- R1: After reset the mask, the status, the alarm, the period and the watchdog reload read zero. The prescaler reads 0x8000, the counter reads 0 and `irq` is low.
- R2: The counter advances once every P slow ticks, where P is the prescaler value at offset 0x08 (0 means 65536), so P=1 advances on every tick. Writing the prescaler clears both the counter and the tick divider.
- R3: The counter is CNT_W bits wide and wraps from all-ones to zero.
- R4: Alarm status (bit 3) sets only when the counter steps onto the value held at offset 0x1C. Loading the value the counter already holds delays the match by one full wrap.
- R5: With period P≠0 at offset 0x00, periodic status (bit 0) sets on every P-th slow tick after the write, and the down-counter reloads. A period of zero stops it.
- R6: With reload W≠0 at offset 0x04, watchdog overflow status (bit 1) sets every W slow ticks. Zero stops it.
- R7: Every counter increment sets status bit 2.
- R8: Reading the status at 0x0C returns the flags and clears them. An event in the same cycle as the read stays set.
- R9: Writing ones at 0x10 sets mask bits and writing ones at 0x14 clears them. Zero bits have no effect. The mask reads at 0x18.
- R10: `irq` is high exactly when some status bit and its mask bit are both set.
- R11: The counter readback at 0x20 changes only after the live count has held for two consecutive clock samples. It follows a settled count within two cycles and stays frozen while the count moves every cycle.
- R12: Writes to the read-only mask (0x18) and counter (0x20) offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during the read cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two situations are hard to reach from the pins. The first is the frozen readback. It only appears while the count changes on every clock, so the bench sets the prescaler to 1, holds `slow_tick` high for twenty cycles while it watches offset 0x20, and then checks that the readback catches up to the full count. The second is the alarm that waits a full wrap. The bench instantiates the block with a 12-bit counter, loads the alarm with the current count and holds the tick high for 4095 cycles before the one increment that must raise the flag. The status-read race is set up by raising the tick in the same cycle as the status read.

// File: rtl/sct_pkg.sv
// Shared definitions for the slow-clock system timer.
// Assumes byte offsets on a word-aligned single-cycle bus.
package sct_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_PERIOD = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_WDOG   = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_PRESC  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_IDIS   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_IMASK  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_ALARM  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h20;

    // Status / mask bit positions (software decodes these)
    localparam int EV_PIT  = 0;
    localparam int EV_WDOV = 1;
    localparam int EV_INC  = 2;
    localparam int EV_ALM  = 3;
    localparam int NUM_EV  = 4;

    typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/sct_rtc.sv
// Prescaled real-time counter.
// Divides slow ticks by the prescaler value (0 means 2**PRE_W) and steps a
// CNT_W-bit wrapping counter. A prescaler write clears divider and counter.
module sct_rtc #(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pre_wr_i,
    input  logic [PRE_W-1:0] pre_val_i,
    output logic [PRE_W-1:0] pre_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             inc_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             term;

    // Divider terminal count; pre_q-1 wraps so that 0 divides by 2**PRE_W
    assign term       = (div_q == pre_q - PRE_W'(1));
    assign inc_o      = tick_i && !pre_wr_i && term;
    assign cnt_next_o = cnt_q + CNT_W'(1);
    assign cnt_o      = cnt_q;
    assign pre_o      = pre_q;

    // Prescaler register, divider and counter state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= PRE_W'(PRE_RST);
            div_q <= '0;
            cnt_q <= '0;
        end else if (pre_wr_i) begin
            pre_q <= pre_val_i;
            div_q <= '0;
            cnt_q <= '0;
        end else if (tick_i) begin
            if (term) begin
                div_q <= '0;
                cnt_q <= cnt_next_o;
            end else begin
                div_q <= div_q + PRE_W'(1);
            end
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/sct_downcnt.sv
// Reloading down-counter clocked by slow ticks.
// A write loads both the period and the count. A zero period stops it.
// Raises evt_o on the tick that expires the count and reloads.
module sct_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] period_o,
    output logic         evt_o
);
    logic [W-1:0] per_q;
    logic [W-1:0] cnt_q;

    assign period_o = per_q;
    assign evt_o    = tick_i && !load_i && (per_q != '0) && (cnt_q <= W'(1));

    // Period register and down-count with reload on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            per_q <= load_val_i;
            cnt_q <= load_val_i;
        end else if (tick_i && per_q != '0) begin
            if (cnt_q <= W'(1)) cnt_q <= per_q;
            else                cnt_q <= cnt_q - W'(1);
        end
    end

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (cnt_q == per_q));
endmodule

// File: rtl/sct_status.sv
// Sticky event status, write-one mask set/clear, and level interrupt.
// A status read clears the flags, but events arriving in that cycle stay set.
module sct_status
    import sct_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t evt_i,
    input  logic    rd_clr_i,
    input  logic    en_wr_i,
    input  logic    dis_wr_i,
    input  ev_vec_t wbits_i,
    output ev_vec_t sts_o,
    output ev_vec_t mask_o,
    output logic    irq_o
);
    ev_vec_t sts_q;
    ev_vec_t mask_q;

    assign sts_o  = sts_q;
    assign mask_o = mask_q;
    assign irq_o  = |(sts_q & mask_q);

    // Sticky flags; new events win over clear-on-read
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (rd_clr_i ? '0 : sts_q) | evt_i;
    end

    // Interrupt mask, set and cleared by write-one registers
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (en_wr_i)  mask_q <= mask_q | wbits_i;
        else if (dis_wr_i) mask_q <= mask_q & ~wbits_i;
    end

    // R8
    clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> (sts_q == $past(evt_i)));
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr_i || dis_wr_i) |=> $stable(mask_q));
endmodule

// File: rtl/slowclk_sys_timer.sv
// Slow-clock system timer top: register decode, alarm compare, and
// glitch-free counter readback. Assumes slow_tick is already a one-cycle
// enable in the bus clock domain.
module slowclk_sys_timer
    import sct_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int PRE_W  = 16,
    parameter int PIT_W  = 16,
    parameter int WDG_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             wr_en, rd_en;
    logic [PRE_W-1:0] pre_val;
    logic [CNT_W-1:0] cnt_live, cnt_next;
    logic             inc;
    logic [PIT_W-1:0] pit_period;
    logic [WDG_W-1:0] wdg_reload;
    logic             pit_evt, wdg_evt;
    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] samp_q, rb_q;
    ev_vec_t          events, sts, mask;
    logic             unused_wdata;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;
    assign unused_wdata = ^bus_wdata;

    sct_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(32768)) u_rtc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (slow_tick),
        .pre_wr_i   (wr_en && bus_addr == OFF_PRESC),
        .pre_val_i  (bus_wdata[PRE_W-1:0]),
        .pre_o      (pre_val),
        .cnt_o      (cnt_live),
        .cnt_next_o (cnt_next),
        .inc_o      (inc)
    );

    sct_downcnt #(.W(PIT_W)) u_pit (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (slow_tick),
        .load_i     (wr_en && bus_addr == OFF_PERIOD),
        .load_val_i (bus_wdata[PIT_W-1:0]),
        .period_o   (pit_period),
        .evt_o      (pit_evt)
    );

    sct_downcnt #(.W(WDG_W)) u_wdg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (slow_tick),
        .load_i     (wr_en && bus_addr == OFF_WDOG),
        .load_val_i (bus_wdata[WDG_W-1:0]),
        .period_o   (wdg_reload),
        .evt_o      (wdg_evt)
    );

    // Alarm register holds an absolute counter value
    always_ff @(posedge clk) begin
        if (!rst_n)                           alarm_q <= '0;
        else if (wr_en && bus_addr == OFF_ALARM) alarm_q <= bus_wdata[CNT_W-1:0];
    end

    // Event vector: alarm fires only when the counter steps onto the value
    always_comb begin
        events          = '0;
        events[EV_PIT]  = pit_evt;
        events[EV_WDOV] = wdg_evt;
        events[EV_INC]  = inc;
        events[EV_ALM]  = inc && (cnt_next == alarm_q);
    end

    sct_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (events),
        .rd_clr_i (rd_en && bus_addr == OFF_STAT),
        .en_wr_i  (wr_en && bus_addr == OFF_IEN),
        .dis_wr_i (wr_en && bus_addr == OFF_IDIS),
        .wbits_i  (bus_wdata[NUM_EV-1:0]),
        .sts_o    (sts),
        .mask_o   (mask),
        .irq_o    (irq)
    );

    // Readback sampler: pass the count on only after two agreeing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            rb_q   <= '0;
        end else begin
            samp_q <= cnt_live;
            if (samp_q == cnt_live) rb_q <= samp_q;
        end
    end

    // Read data mux
    always_comb begin
        case (bus_addr)
            OFF_PERIOD: bus_rdata = DATA_W'(pit_period);
            OFF_WDOG:   bus_rdata = DATA_W'(wdg_reload);
            OFF_PRESC:  bus_rdata = DATA_W'(pre_val);
            OFF_STAT:   bus_rdata = DATA_W'(sts);
            OFF_IMASK:  bus_rdata = DATA_W'(mask);
            OFF_ALARM:  bus_rdata = DATA_W'(alarm_q);
            OFF_COUNT:  bus_rdata = DATA_W'(rb_q);
            default:    bus_rdata = '0;
        endcase
    end

    // R11
    rb_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rb_q) |-> (rb_q == $past(cnt_live)));
    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: tb/slowclk_sys_timer_tb.sv
module slowclk_sys_timer_tb;
    localparam int CNT_W = 12;
    localparam logic [5:0] A_PER = 6'h00, A_WDG = 6'h04, A_PRE = 6'h08,
        A_STAT = 6'h0C, A_IEN = 6'h10, A_IDIS = 6'h14, A_MASK = 6'h18,
        A_ALM = 6'h1C, A_CNT = 6'h20;

    logic        clk = 0, rst_n = 0, slow_tick = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          checks = 0, errors = 0;
    logic [31:0] rd;
    logic [31:0] v0;

    always #2.5 clk = ~clk;

    slowclk_sys_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {write, addr, data/expected}
    localparam int NV = 22;
    localparam logic [38:0] VECS [0:NV-1] = '{
        {1'b1, A_IEN,  32'h5},   {1'b0, A_MASK, 32'h5},   // R9 set
        {1'b1, A_IEN,  32'h0},   {1'b0, A_MASK, 32'h5},   // R9 zero no effect
        {1'b1, A_IDIS, 32'h4},   {1'b0, A_MASK, 32'h1},   // R9 clear
        {1'b1, A_IDIS, 32'h0},   {1'b0, A_MASK, 32'h1},   // R9 zero no effect
        {1'b1, A_MASK, 32'hF},   {1'b0, A_MASK, 32'h1},   // R12 mask read-only
        {1'b1, A_ALM,  32'h123}, {1'b0, A_ALM,  32'h123}, // R4 alarm register
        {1'b1, A_PER,  32'h7},   {1'b0, A_PER,  32'h7},   // R5 period register
        {1'b1, A_CNT,  32'h55},  {1'b0, A_CNT,  32'h0},   // R12 counter read-only
        {1'b1, A_WDG,  32'h9},   {1'b0, A_WDG,  32'h9},   // R6 reload register
        {1'b1, A_PRE,  32'h3},   {1'b0, A_PRE,  32'h3},   // R2 prescaler register
        {1'b1, A_IDIS, 32'hF},   {1'b0, A_MASK, 32'h0}    // R9 clear all
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic read_cnt(output logic [31:0] d);
        repeat (3) @(negedge clk);
        do_read(A_CNT, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1;
            @(negedge clk); slow_tick = 0;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        do_read(A_MASK, rd); chk("R1 mask", rd, 0);
        do_read(A_STAT, rd); chk("R1 status", rd, 0);
        do_read(A_ALM, rd);  chk("R1 alarm", rd, 0);
        do_read(A_PRE, rd);  chk("R1 prescaler", rd, 32'h8000);
        do_read(A_CNT, rd);  chk("R1 counter", rd, 0);
        do_read(A_PER, rd);  chk("R1 period", rd, 0);
        do_read(A_WDG, rd);  chk("R1 watchdog", rd, 0);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][38]) do_write(VECS[i][37:32], VECS[i][31:0]);
            else begin
                do_read(VECS[i][37:32], rd);
                chk($sformatf("table %0d", i), rd, VECS[i][31:0]);
            end
        end

        do_write(A_PER, 0); do_write(A_WDG, 0);
        do_read(A_STAT, rd);

        // R2 prescale of 3, R7 increment flag
        ticks(2); read_cnt(rd); chk("R2 no step before 3 ticks", rd, 0);
        do_read(A_STAT, rd); chk("R7 no inc flag yet", rd, 0);
        ticks(1); read_cnt(rd); chk("R2 step on 3rd tick", rd, 1);
        do_read(A_STAT, rd); chk("R7 inc flag", rd, 4);
        ticks(3); read_cnt(rd); chk("R2 second step", rd, 2);
        do_write(A_PRE, 1); read_cnt(rd); chk("R2 prescaler write clears", rd, 0);
        ticks(1); read_cnt(rd); chk("R2 prescale 1", rd, 1);

        // R11 readback frozen while count moves every cycle
        v0 = 1;
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = A_CNT; slow_tick = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i < 19) begin
                if (i % 5 == 0) chk("R11 frozen readback", bus_rdata, v0);
            end else slow_tick = 0;
        end
        repeat (3) @(negedge clk);
        chk("R11 settled readback", bus_rdata, v0 + 20);
        bus_sel = 0;

        // R3 wrap, R4 alarm at current count waits a full wrap
        do_write(A_PRE, 1); do_write(A_ALM, 0);
        do_read(A_STAT, rd);
        @(negedge clk); slow_tick = 1;
        repeat ((1 << CNT_W) - 1) @(negedge clk);
        slow_tick = 0;
        do_read(A_STAT, rd); chk("R4 no alarm before wrap", rd, 4);
        read_cnt(rd); chk("R3 all-ones count", rd, (1 << CNT_W) - 1);
        ticks(1);
        do_read(A_STAT, rd); chk("R4 alarm after wrap", rd, 32'hC);
        read_cnt(rd); chk("R3 wraps to zero", rd, 0);

        // R4 alarm two ahead
        do_write(A_ALM, 2);
        ticks(1); do_read(A_STAT, rd); chk("R4 not yet", rd, 4);
        ticks(1); do_read(A_STAT, rd); chk("R4 match", rd, 32'hC);

        // R5 periodic
        do_write(A_PER, 3); do_read(A_STAT, rd);
        ticks(2); do_read(A_STAT, rd); chk("R5 before period", rd, 4);
        ticks(1); do_read(A_STAT, rd); chk("R5 first period", rd, 5);
        ticks(3); do_read(A_STAT, rd); chk("R5 reload period", rd, 5);
        do_write(A_PER, 0);
        ticks(5); do_read(A_STAT, rd); chk("R5 stopped", rd, 4);

        // R6 watchdog overflow
        do_write(A_WDG, 4);
        ticks(3); do_read(A_STAT, rd); chk("R6 before overflow", rd, 4);
        ticks(1); do_read(A_STAT, rd); chk("R6 overflow", rd, 6);
        do_write(A_WDG, 0);
        ticks(6); do_read(A_STAT, rd); chk("R6 stopped", rd, 4);

        // R8 event during the status read survives
        do_read(A_STAT, rd); chk("R8 cleared by read", rd, 0);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = A_STAT; slow_tick = 1;
        #1 rd = bus_rdata;
        @(negedge clk); bus_sel = 0; slow_tick = 0;
        chk("R8 read value", rd, 0);
        do_read(A_STAT, rd); chk("R8 same-cycle event kept", rd, 4);

        // R10 interrupt
        do_write(A_IEN, 1); do_write(A_PER, 2); do_read(A_STAT, rd);
        ticks(1); chk("R10 irq low", {31'b0, irq}, 0);
        ticks(1); chk("R10 irq high", {31'b0, irq}, 1);
        do_read(A_STAT, rd); chk("R10 irq cleared", {31'b0, irq}, 0);
        ticks(2); chk("R10 irq again", {31'b0, irq}, 1);
        do_write(A_IDIS, 1); chk("R10 masked off", {31'b0, irq}, 0);
        do_write(A_IEN, 1);  chk("R10 unmasked pending", {31'b0, irq}, 1);

        finish_run();
    end
endmodule